// File: doc/BRIEF.md
# Serial Management Bus Target Decoder

This block is the device side of a two-wire serial management bus of the IEEE 802.3 clause 22 kind. It runs on the management clock and samples the data line on each rising edge. It looks for a start-of-frame pattern, with or without a leading run of preamble ones. It then decodes the operation, the 5-bit device address and the 5-bit register address. When a read is addressed to the configured local device, it takes over the line for the turnaround and the data field. When a write is addressed to it, it collects the data field and hands it to an attached register file with a single-cycle strobe.

The line is shared with extended-addressing (clause 45) devices. A frame whose start pattern is two zeros is counted through to its end and ignored. The block never drives the line for such a frame, and the frame cannot be mistaken for a clause 22 frame. The register file is plain: the block presents a register address, reads a combinational data input, and issues write data with a write enable.

Top module: `mdio_target`

## Requirements
- R1: A frame is accepted whether its start pattern follows a run of up to 32 ones or follows idle directly (no preamble).
- R2: A start pattern of 0 then 0 makes the block ignore the next 30 bit times: it does not drive the line and issues no write strobe. A clause 22 frame that follows straight after is served.
- R3: The two operation bits 1,0 select a read and 0,1 select a write. The values 0,0 and 1,1 abandon the frame and return to start hunting, with no drive and no strobe.
- R4: The 5-bit device address, received most significant bit first, must equal `phy_addr_i`. Otherwise the block neither drives the line nor strobes for the rest of that frame.
- R5: The 5-bit register address, received most significant bit first, appears on `reg_addr_o` once its last bit has been sampled. It stays there through the end of the frame and accompanies the write strobe.
- R6: On an addressed read, the line is left undriven for the first turnaround bit, and the block drives 0 for the second.
- R7: On an addressed read, the 16 data bits are sent most significant bit first. They come from `rd_data_i`, which is captured at the clock edge that samples the first turnaround bit. Later changes on `rd_data_i` do not alter the bits sent.
- R8: The output enable drops at the clock edge that ends the last data bit time. At all other times outside an addressed read's second turnaround bit and data field, the line is left undriven.
- R9: On a write with the turnaround check enabled, the turnaround bits must be 1 then 0. Any other turnaround value drops the frame without a strobe.
- R10: After the 16th write data bit of an addressed write, `wr_en_o` is high for exactly one clock. During that clock `wr_data_o` holds the received word (first bit received is bit 15).
- R11: While `rst_n` is low, the output enable and the write strobe are low and the block returns to start hunting, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Active-low reset in the management clock domain |
| phy_addr_i | input | ADDR_W | Local device address that frames must match |
| mdio_i | input | 1 | Sampled value of the shared data line |
| mdio_o | output | 1 | Value driven onto the line when enabled |
| mdio_oe | output | 1 | Output enable for the line driver; low means high impedance |
| reg_addr_o | output | ADDR_W | Register address of the current frame |
| rd_data_i | input | DATA_W | Read data from the register file for `reg_addr_o` |
| wr_en_o | output | 1 | One-clock write strobe to the register file |
| wr_data_o | output | DATA_W | Write data accompanying the strobe |

## Verification
The bench builds the block with a 16-bit data field, 5-bit address fields and the turnaround check enabled. This is the real frame geometry, so the 30-bit skip for extended frames and the 18-bit skip for foreign addresses run at full length. With those values the bench can check, at bit level, the turnaround on the line, the capture point of read data, and the tail of a skipped frame running straight into a served frame with no preamble. The check-enabled variant puts rejection of bad write turnarounds within the bench's reach.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   typedef enum logic [2:0] {
      FS_HUNT,
      FS_START,
      FS_OPCODE,
      FS_PHYAD,
      FS_REGAD,
      FS_TURN,
      FS_DATA,
      FS_SKIP
   } fstate_t;

   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_WRITE = 2'b01;

endpackage

// File: rtl/mdio_rx_history.sv
module mdio_rx_history #(
   parameter int HIST_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_i,
   output logic [HIST_W-1:0] hist_o
);

   if (HIST_W < 1) begin : g_bad_width
      $error("mdio_rx_history: HIST_W must be at least 1");
   end

   // Holds the bits sampled at earlier edges; the newest is bit 0.
   if (HIST_W == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hist_o <= '0;
         else        hist_o <= bit_i;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hist_o <= '0;
         else        hist_o <= {hist_o[HIST_W-2:0], bit_i};
      end
   end

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
   import mdio_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 5,
   parameter bit TA_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_i,
   input  logic [DATA_W-2:0] hist_i,
   input  logic [ADDR_W-1:0] phy_addr_i,
   output fstate_t           state_o,
   output logic              rd_frame_o,
   output logic              tx_load_o,
   output logic              tx_shift_o,
   output logic              tx_stop_o,
   output logic [ADDR_W-1:0] reg_addr_o,
   output logic              wr_en_o,
   output logic [DATA_W-1:0] wr_data_o
);

   // Bits after a clause 45 start pattern: opcode, two address fields, turnaround, data.
   localparam int SKIP_C45  = 2 + 2 * ADDR_W + 2 + DATA_W;
   // Bits after the register address of a frame for another device.
   localparam int SKIP_MISS = 2 + DATA_W;
   localparam int CNT_W     = $clog2(SKIP_C45);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("mdio_frame_fsm: ADDR_W must be at least 2");
   end
   if (DATA_W < ADDR_W) begin : g_bad_data
      $error("mdio_frame_fsm: DATA_W must not be below ADDR_W");
   end

   fstate_t           st;
   logic [CNT_W-1:0]  cnt;
   logic              rd_q;
   logic              hit_q;
   logic              last;
   logic              ta_fail;
   logic [1:0]        pair;
   logic [ADDR_W-1:0] field;

   assign last  = (cnt == '0);
   assign pair  = {hist_i[0], bit_i};
   assign field = {hist_i[ADDR_W-2:0], bit_i};

   if (TA_CHECK) begin : g_ta_check
      // Write turnaround must read 1 then 0.
      assign ta_fail = !rd_q && (last ? bit_i : !bit_i);
   end else begin : g_ta_free
      assign ta_fail = 1'b0;
   end

   assign tx_load_o  = rd_q && (st == FS_TURN) && !last;
   assign tx_shift_o = rd_q && (((st == FS_TURN) && last) || ((st == FS_DATA) && !last));
   assign tx_stop_o  = rd_q && (st == FS_DATA) && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= FS_HUNT;
         cnt        <= '0;
         rd_q       <= 1'b0;
         hit_q      <= 1'b0;
         reg_addr_o <= '0;
         wr_en_o    <= 1'b0;
         wr_data_o  <= '0;
      end else begin
         wr_en_o <= 1'b0;
         unique case (st)
            FS_HUNT: begin
               if (!bit_i) st <= FS_START;
            end
            FS_START: begin
               if (bit_i) begin
                  st  <= FS_OPCODE;
                  cnt <= CNT_W'(1);
               end else begin
                  st  <= FS_SKIP;
                  cnt <= CNT_W'(SKIP_C45 - 1);
               end
            end
            FS_OPCODE: begin
               if (!last) begin
                  cnt <= cnt - 1'b1;
               end else if (pair == OPC_READ || pair == OPC_WRITE) begin
                  rd_q <= (pair == OPC_READ);
                  st   <= FS_PHYAD;
                  cnt  <= CNT_W'(ADDR_W - 1);
               end else begin
                  st <= FS_HUNT;
               end
            end
            FS_PHYAD: begin
               if (!last) begin
                  cnt <= cnt - 1'b1;
               end else begin
                  hit_q <= (field == phy_addr_i);
                  st    <= FS_REGAD;
                  cnt   <= CNT_W'(ADDR_W - 1);
               end
            end
            FS_REGAD: begin
               if (!last) begin
                  cnt <= cnt - 1'b1;
               end else begin
                  reg_addr_o <= field;
                  if (hit_q) begin
                     st  <= FS_TURN;
                     cnt <= CNT_W'(1);
                  end else begin
                     st  <= FS_SKIP;
                     cnt <= CNT_W'(SKIP_MISS - 1);
                  end
               end
            end
            FS_TURN: begin
               if (ta_fail) begin
                  st <= FS_HUNT;
               end else if (last) begin
                  st  <= FS_DATA;
                  cnt <= CNT_W'(DATA_W - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            FS_DATA: begin
               if (!last) begin
                  cnt <= cnt - 1'b1;
               end else begin
                  st <= FS_HUNT;
                  if (!rd_q) begin
                     wr_en_o   <= 1'b1;
                     wr_data_o <= {hist_i, bit_i};
                  end
               end
            end
            FS_SKIP: begin
               if (last) st <= FS_HUNT;
               else      cnt <= cnt - 1'b1;
            end
            default: st <= FS_HUNT;
         endcase
      end
   end

   assign state_o    = st;
   assign rd_frame_o = rd_q;

   a_r10_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> !wr_en_o);

   a_r3_no_strobe_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> !rd_q);

   a_r10_strobe_from_data: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_en_o) |-> $past(st) == FS_DATA);

endmodule

// File: rtl/mdio_read_shifter.sv
module mdio_read_shifter #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              shift_i,
   input  logic              stop_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              mdio_o,
   output logic              mdio_oe
);

   if (DATA_W < 2) begin : g_bad_width
      $error("mdio_read_shifter: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '0;
         mdio_o  <= 1'b0;
         mdio_oe <= 1'b0;
      end else if (stop_i) begin
         mdio_o  <= 1'b0;
         mdio_oe <= 1'b0;
      end else if (load_i) begin
         // Second turnaround bit time: drive a zero, hold the word.
         sh      <= data_i;
         mdio_o  <= 1'b0;
         mdio_oe <= 1'b1;
      end else if (shift_i) begin
         mdio_o <= sh[DATA_W-1];
         sh     <= {sh[DATA_W-2:0], 1'b0};
      end
   end

   a_r6_turn_drives_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdio_oe) |-> !mdio_o);

   a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !mdio_oe |-> !mdio_o);

endmodule

// File: rtl/mdio_target.sv
module mdio_target
   import mdio_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 5,
   parameter bit TA_CHECK = 1'b1
) (
   input  logic              mdc,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] phy_addr_i,
   input  logic              mdio_i,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic [ADDR_W-1:0] reg_addr_o,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              wr_en_o,
   output logic [DATA_W-1:0] wr_data_o
);

   localparam int HIST_W = DATA_W - 1;

   logic [HIST_W-1:0] hist;
   fstate_t           state;
   logic              rd_frame;
   logic              tx_load;
   logic              tx_shift;
   logic              tx_stop;

   mdio_rx_history #(
      .HIST_W (HIST_W)
   ) u_hist (
      .clk    (mdc),
      .rst_n  (rst_n),
      .bit_i  (mdio_i),
      .hist_o (hist)
   );

   mdio_frame_fsm #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .TA_CHECK (TA_CHECK)
   ) u_fsm (
      .clk        (mdc),
      .rst_n      (rst_n),
      .bit_i      (mdio_i),
      .hist_i     (hist),
      .phy_addr_i (phy_addr_i),
      .state_o    (state),
      .rd_frame_o (rd_frame),
      .tx_load_o  (tx_load),
      .tx_shift_o (tx_shift),
      .tx_stop_o  (tx_stop),
      .reg_addr_o (reg_addr_o),
      .wr_en_o    (wr_en_o),
      .wr_data_o  (wr_data_o)
   );

   mdio_read_shifter #(
      .DATA_W (DATA_W)
   ) u_tx (
      .clk     (mdc),
      .rst_n   (rst_n),
      .load_i  (tx_load),
      .shift_i (tx_shift),
      .stop_i  (tx_stop),
      .data_i  (rd_data_i),
      .mdio_o  (mdio_o),
      .mdio_oe (mdio_oe)
   );

   a_r3_drive_reads_only: assert property (@(posedge mdc) disable iff (!rst_n)
      mdio_oe |-> rd_frame);

   a_r4_drive_window: assert property (@(posedge mdc) disable iff (!rst_n)
      mdio_oe |-> (state == FS_TURN || state == FS_DATA));

   a_r8_release_at_end: assert property (@(posedge mdc) disable iff (!rst_n)
      $fell(mdio_oe) |-> state == FS_HUNT);

   a_r10_no_strobe_while_driving: assert property (@(posedge mdc) disable iff (!rst_n)
      mdio_oe |-> !wr_en_o);

endmodule

// File: tb/tb_mdio_target.sv
module tb_mdio_target;

   localparam int DW = 16;
   localparam int AW = 5;
   localparam logic [AW-1:0] MY_ADDR = 5'd9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_oe = 1'b0;
   logic          host_val = 1'b1;
   logic          mdio_bus;
   logic          mdio_o, mdio_oe, wr_en;
   logic [AW-1:0] reg_addr;
   logic [DW-1:0] rd_data, wr_data;
   logic [DW-1:0] regs [32];
   logic [DW-1:0] mdl  [32];

   int total = 0, bad = 0, clash = 0, strobes = 0;
   bit done = 1'b0;

   typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } wexp_t;
   wexp_t wq[$];

   always #4 clk = ~clk;

   assign mdio_bus = mdio_oe ? mdio_o : (host_oe ? host_val : 1'b1);
   assign rd_data  = regs[reg_addr];

   mdio_target #(.DATA_W(DW), .ADDR_W(AW), .TA_CHECK(1'b1)) dut (
      .mdc        (clk),
      .rst_n      (rst_n),
      .phy_addr_i (MY_ADDR),
      .mdio_i     (mdio_bus),
      .mdio_o     (mdio_o),
      .mdio_oe    (mdio_oe),
      .reg_addr_o (reg_addr),
      .rd_data_i  (rd_data),
      .wr_en_o    (wr_en),
      .wr_data_o  (wr_data)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drv(input logic b);
      @(negedge clk);
      host_oe  = 1'b1;
      host_val = b;
   endtask

   task automatic drv_bits(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) drv(v[i]);
   endtask

   task automatic rel(output logic b, output logic oe);
      @(negedge clk);
      host_oe = 1'b0;
      #1;
      b  = mdio_bus;
      oe = mdio_oe;
   endtask

   // Scoreboard monitor: pops the expected write for every strobe seen.
   always @(negedge clk) begin
      if (rst_n && wr_en) begin
         strobes++;
         if (wq.size() == 0) begin
            chk(1'b0, "R10 unexpected write strobe", {11'd0, reg_addr, wr_data}, 32'd0);
         end else begin
            wexp_t e;
            e = wq.pop_front();
            chk(reg_addr == e.a, "R5 write register address", reg_addr, e.a);
            chk(wr_data == e.d, "R10 write data", wr_data, e.d);
            regs[reg_addr] = wr_data;
         end
      end
   end

   always @(negedge clk) begin
      #2;
      if (host_oe && mdio_oe) clash++;
   end

   task automatic wr_frame(input int pre, input logic [AW-1:0] phy, input logic [AW-1:0] ra,
                           input logic [DW-1:0] d, input logic [1:0] ta, input bit expect_hit);
      if (expect_hit) begin
         wexp_t e;
         e.a = ra;
         e.d = d;
         wq.push_back(e);
         mdl[ra] = d;
      end
      repeat (pre) drv(1'b1);
      drv_bits({2'b01, 2'b01, phy, ra, ta, d}, 32);
      drv(1'b1);
      drv(1'b1);
   endtask

   task automatic rd_frame(input int pre, input logic [AW-1:0] phy, input logic [AW-1:0] ra,
                           input bit hit, input bit corrupt);
      logic b, oe;
      logic [DW-1:0] got;
      int oes;
      repeat (pre) drv(1'b1);
      drv_bits({18'd0, 2'b01, 2'b10, phy, ra}, 14);
      rel(b, oe);
      chk(!oe && b, "R6 first turnaround bit undriven", {oe, b}, 2'b01);
      rel(b, oe);
      if (hit) chk(oe && !b, "R6 second turnaround bit driven low", {oe, b}, 2'b10);
      else     chk(!oe, "R4 no drive for foreign address", oe, 0);
      if (corrupt) regs[ra] = ~mdl[ra];
      got = '0;
      oes = 0;
      for (int i = 0; i < DW; i++) begin
         rel(b, oe);
         got = {got[DW-2:0], b};
         oes += int'(oe);
      end
      if (hit) begin
         chk(got == mdl[ra], "R7 read data MSB first", got, mdl[ra]);
         chk(oes == DW, "R7 data field fully driven", oes, DW);
      end else begin
         chk(oes == 0, "R4 data field undriven for foreign address", oes, 0);
      end
      rel(b, oe);
      chk(!oe, "R8 released after last data bit", oe, 0);
      if (corrupt) regs[ra] = mdl[ra];
      drv(1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         chk(1'b0, "watchdog expired", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic b, oe;
      int s0, oes;
      for (int i = 0; i < 32; i++) begin
         regs[i] = 16'h3C00 ^ DW'(i * 16'h0111);
         mdl[i]  = regs[i];
      end
      repeat (3) @(negedge clk);
      #1;
      // R11: reset state
      chk(!mdio_oe && !wr_en && mdio_bus, "R11 reset outputs", {mdio_oe, wr_en, mdio_bus}, 3'b001);
      @(negedge clk);
      rst_n = 1'b1;
      drv(1'b1);

      // R1 with and without preamble, R5, R10 boundary values
      wr_frame(32, MY_ADDR, 5'd0, 16'hFFFF, 2'b10, 1'b1);
      wr_frame(0, MY_ADDR, 5'd31, 16'h0000, 2'b10, 1'b1);
      wr_frame(5, MY_ADDR, 5'd17, 16'hA5C3, 2'b10, 1'b1);
      rd_frame(32, MY_ADDR, 5'd0, 1'b1, 1'b0);
      rd_frame(0, MY_ADDR, 5'd31, 1'b1, 1'b0);
      rd_frame(3, MY_ADDR, 5'd17, 1'b1, 1'b0);
      rd_frame(0, MY_ADDR, 5'd6, 1'b1, 1'b0);

      // R7: register file changes after capture do not reach the line
      rd_frame(32, MY_ADDR, 5'd17, 1'b1, 1'b1);

      // R4: foreign address
      s0 = strobes;
      wr_frame(32, 5'd10, 5'd4, 16'h0000, 2'b10, 1'b0);
      chk(strobes == s0, "R4 no strobe for foreign address", strobes - s0, 0);
      rd_frame(32, 5'd8, 5'd4, 1'b0, 1'b0);

      // R2: clause 45 read frame, then an immediate clause 22 read without preamble
      repeat (32) drv(1'b1);
      drv_bits({18'd0, 2'b00, 2'b11, MY_ADDR, 5'd3}, 14);
      oes = 0;
      for (int i = 0; i < 18; i++) begin
         rel(b, oe);
         oes += int'(oe);
      end
      chk(oes == 0, "R2 extended frame left undriven", oes, 0);
      rd_frame(0, MY_ADDR, 5'd31, 1'b1, 1'b0);

      // R2: clause 45 write-like frame with zero data gives no strobe
      s0 = strobes;
      repeat (32) drv(1'b1);
      drv_bits({2'b00, 2'b01, MY_ADDR, 5'd3, 2'b10, 16'h0000}, 32);
      drv(1'b1);
      drv(1'b1);
      chk(strobes == s0, "R2 no strobe for extended frame", strobes - s0, 0);
      wr_frame(0, MY_ADDR, 5'd12, 16'h1234, 2'b10, 1'b1);

      // R3: invalid opcodes abandon the frame
      s0 = strobes;
      repeat (8) drv(1'b1);
      drv_bits(32'b0100, 4);
      repeat (30) drv(1'b1);
      drv_bits(32'b0111, 4);
      repeat (30) drv(1'b1);
      chk(strobes == s0, "R3 no strobe for invalid opcode", strobes - s0, 0);
      chk(clash == 0, "R3 no drive for invalid opcode", clash, 0);
      wr_frame(0, MY_ADDR, 5'd12, 16'h8001, 2'b10, 1'b1);
      rd_frame(0, MY_ADDR, 5'd12, 1'b1, 1'b0);

      // R9: bad write turnaround drops the frame
      s0 = strobes;
      wr_frame(32, MY_ADDR, 5'd20, 16'hFFFF, 2'b11, 1'b0);
      wr_frame(32, MY_ADDR, 5'd20, 16'hFFFF, 2'b01, 1'b0);
      repeat (4) drv(1'b1);
      chk(strobes == s0, "R9 no strobe after bad turnaround", strobes - s0, 0);
      rd_frame(32, MY_ADDR, 5'd20, 1'b1, 1'b0);

      // R11: reset in the middle of a read frame
      repeat (32) drv(1'b1);
      drv_bits({2'b01, 2'b10, MY_ADDR, 3'b010}, 12);
      @(negedge clk);
      rst_n   = 1'b0;
      host_val = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      chk(!mdio_oe && !wr_en, "R11 mid-frame reset outputs", {mdio_oe, wr_en}, 2'b00);
      rst_n = 1'b1;
      drv(1'b1);
      rd_frame(0, MY_ADDR, 5'd17, 1'b1, 1'b0);

      repeat (4) drv(1'b1);
      chk(wq.size() == 0, "R10 every expected strobe seen", wq.size(), 0);
      chk(clash == 0, "R8 no drive while host drives", clash, 0);

      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule